// File: doc/BRIEF.md
# Misc system control register block

This block is a small bank of byte, halfword and word control registers that sits on a simple synchronous register bus inside a workstation I/O controller. Software uses it to configure the power-fail interrupt, to hold general-purpose auxiliary, diagnostic and modem-control bytes, to drive a 16-bit diagnostic LED pattern, and to request a system reset, a power-off or a CPU halt. Each request leaves the block as a one-cycle registered pulse for the surrounding power and clock logic to act on.

An asynchronous power-failing input is brought in through a two-flop synchronizer. A change of the synchronized level loads a power-fail flag, which is gated by an enable bit in the configuration byte; the level interrupt output follows that flag and the enable bit. Software acknowledges the interrupt with a write-one-to-clear bit. Block reset clears the configuration, both auxiliary bytes and the modem byte, but leaves the diagnostic byte, the LED pattern and the system-control word untouched, so a reset-status flag survives the very reset it asked for.

Top module: `sysctl_misc_regs`

## Requirements
- R1: A register is selected by address bits 27:16 with bits 15:0 all zero; bits 31:28 are ignored. Selector values: 0x160 LED pattern, 0x180 configuration, 0x190 aux-one, 0x191 aux-two, 0x192 halt location, 0x1A0 diagnostic, 0x1B0 modem control, 0x1F0 system control.
- R2: The interrupt output is high exactly when aux-two bit 5 (power-fail flag) and configuration bit 3 (power-fail interrupt enable) are both set; it follows every configuration and aux-two write.
- R3: The power-failing input passes through two synchronizing flops; whenever the synchronized level changes, aux-two bit 5 is loaded with that level ANDed with configuration bit 3.
- R4: On an aux-two write only data bits 1:0 are taken; bit 0 is stored, bit 5 keeps its value unless data bit 1 is one, in which case bit 5 is cleared; bit 1 and all other bits read back as zero.
- R5: An aux-two write with data bit 0 set produces a power-off pulse that is high for exactly the one cycle after the write.
- R6: A system-control write with data bit 0 set loads the word with 0x00000002 and produces a one-cycle system-reset pulse in the cycle after the write; a write with bit 0 clear changes nothing and makes no pulse.
- R7: Reset clears configuration, aux-one, aux-two and modem control, and keeps the diagnostic byte, the LED pattern and the system-control word.
- R8: Any write to the halt location produces a one-cycle CPU-halt pulse in the cycle after the write; reading the halt location returns zero.
- R9: Reads of undecoded addresses return zero and writes to them change no register and make no pulse.
- R10: Read data is registered: it appears in the cycle after the read enable; byte registers and the 16-bit LED pattern are zero-extended to 32 bits.
- R11: Configuration, aux-one, diagnostic and modem control store all eight written data bits and read them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Register address |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| pwrFailIn | input | 1 | Asynchronous power-failing indication |
| irq | output | 1 | Level power-fail interrupt |
| pwrOffReq | output | 1 | One-cycle power-off request |
| sysRstReq | output | 1 | One-cycle system-reset request |
| cpuHaltReq | output | 1 | One-cycle CPU-halt request |

## Verification
The assertions assume that a write to aux-two is never in the same cycle as a change of the synchronized power-fail level, since the property on the clear bit only constrains cycles without such a change, and that every access lasts a single cycle. The stimulus respects this by changing the power-failing input only while the bus is idle and waiting several cycles for the synchronizer to settle before the next aux-two access. Reads and writes are never issued together, and the power-failing input is returned low before each reset so no spurious edge appears afterwards.

// File: rtl/sysctl_misc_pkg.sv
package sysctl_misc_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int KEY_LSB  = 16;
  localparam int KEY_MSB  = 27;
  localparam int KEY_W    = KEY_MSB - KEY_LSB + 1;
  localparam int BYTE_W   = 8;
  localparam int LED_W    = 16;
  localparam int SYNC_STAGES = 2;

  localparam logic [KEY_W-1:0] KEY_LED  = 12'h160;
  localparam logic [KEY_W-1:0] KEY_CFG  = 12'h180;
  localparam logic [KEY_W-1:0] KEY_AUX1 = 12'h190;
  localparam logic [KEY_W-1:0] KEY_AUX2 = 12'h191;
  localparam logic [KEY_W-1:0] KEY_HALT = 12'h192;
  localparam logic [KEY_W-1:0] KEY_DIAG = 12'h1A0;
  localparam logic [KEY_W-1:0] KEY_MDM  = 12'h1B0;
  localparam logic [KEY_W-1:0] KEY_SYS  = 12'h1F0;

  localparam int CFG_PFEN_BIT  = 3;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_PF_BIT   = 5;
  localparam int SYS_GO_BIT    = 0;
  localparam logic [DATA_W-1:0] SYS_STATUS_VAL = 32'h0000_0002;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_AUX1, SEL_AUX2, SEL_DIAG,
    SEL_MDM, SEL_LED, SEL_SYS, SEL_HALT
  } regSel_e;

  typedef struct packed {
    logic    cfgWr;
    logic    aux1Wr;
    logic    aux2Wr;
    logic    diagWr;
    logic    mdmWr;
    logic    ledWr;
    logic    sysWr;
    logic    haltWr;
    regSel_e rdSel;
  } busStrobe_t;
endpackage

// File: rtl/sysctl_misc_sync.sv
module sysctl_misc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sysctl_misc_ctrl.sv
module sysctl_misc_ctrl
  import sysctl_misc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output busStrobe_t        stb
);
  logic [KEY_W-1:0] key;
  logic             lowZero;
  regSel_e          hitSel;
  logic             unusedHi;

  assign key      = addr[KEY_MSB:KEY_LSB];
  assign lowZero  = (addr[KEY_LSB-1:0] == '0);
  assign unusedHi = ^addr[ADDR_W-1:KEY_MSB+1];

  always_comb begin
    hitSel = SEL_NONE;
    if (lowZero) begin
      case (key)
        KEY_CFG:  hitSel = SEL_CFG;
        KEY_AUX1: hitSel = SEL_AUX1;
        KEY_AUX2: hitSel = SEL_AUX2;
        KEY_DIAG: hitSel = SEL_DIAG;
        KEY_MDM:  hitSel = SEL_MDM;
        KEY_LED:  hitSel = SEL_LED;
        KEY_SYS:  hitSel = SEL_SYS;
        KEY_HALT: hitSel = SEL_HALT;
        default:  hitSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    stb        = '0;
    stb.rdSel  = rdEn ? hitSel : SEL_NONE;
    stb.cfgWr  = wrEn && (hitSel == SEL_CFG);
    stb.aux1Wr = wrEn && (hitSel == SEL_AUX1);
    stb.aux2Wr = wrEn && (hitSel == SEL_AUX2);
    stb.diagWr = wrEn && (hitSel == SEL_DIAG);
    stb.mdmWr  = wrEn && (hitSel == SEL_MDM);
    stb.ledWr  = wrEn && (hitSel == SEL_LED);
    stb.sysWr  = wrEn && (hitSel == SEL_SYS);
    stb.haltWr = wrEn && (hitSel == SEL_HALT);
  end

  // R9: at most one register is written per access
  a_r9_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cfgWr, stb.aux1Wr, stb.aux2Wr, stb.diagWr,
              stb.mdmWr, stb.ledWr, stb.sysWr, stb.haltWr}));

  // R9: nothing is written when the low address half is nonzero
  a_r9_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !lowZero) |-> !(stb.cfgWr || stb.sysWr || stb.aux2Wr || stb.haltWr));
endmodule

// File: rtl/sysctl_misc_dp.sv
module sysctl_misc_dp
  import sysctl_misc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pwrFailIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              pwrOffReq,
  output logic              sysRstReq,
  output logic              cpuHaltReq
);
  logic [BYTE_W-1:0] cfgQ, aux1Q, diagQ, mdmQ;
  logic              auxOffQ, auxPfQ;
  logic [LED_W-1:0]  ledQ;
  logic [DATA_W-1:0] sysQ;
  logic              pfSync, pfPrevQ, pfEdge;
  logic [DATA_W-1:0] rdMux;
  logic [BYTE_W-1:0] aux2View;
  logic              unusedWd;

  assign unusedWd = ^wrData[DATA_W-1:LED_W];

  sysctl_misc_sync #(.STAGES(SYNC_STAGES)) u_pfSync (
    .clk(clk), .rstN(rstN), .d(pwrFailIn), .q(pfSync)
  );

  assign pfEdge = pfSync ^ pfPrevQ;

  // Registers cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      aux1Q   <= '0;
      mdmQ    <= '0;
      auxOffQ <= 1'b0;
      auxPfQ  <= 1'b0;
      pfPrevQ <= 1'b0;
    end else begin
      pfPrevQ <= pfSync;
      if (stb.cfgWr)  cfgQ  <= wrData[BYTE_W-1:0];
      if (stb.aux1Wr) aux1Q <= wrData[BYTE_W-1:0];
      if (stb.mdmWr)  mdmQ  <= wrData[BYTE_W-1:0];
      if (stb.aux2Wr) begin
        auxOffQ <= wrData[AUX2_OFF_BIT];
        if (wrData[AUX2_CLR_BIT]) auxPfQ <= 1'b0;
      end
      if (pfEdge) auxPfQ <= pfSync & cfgQ[CFG_PFEN_BIT];
    end
  end

  // Registers that keep their value across reset
  always_ff @(posedge clk) begin
    if (stb.diagWr) diagQ <= wrData[BYTE_W-1:0];
    if (stb.ledWr)  ledQ  <= wrData[LED_W-1:0];
    if (stb.sysWr && wrData[SYS_GO_BIT]) sysQ <= SYS_STATUS_VAL;
  end

  // Request pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrOffReq  <= 1'b0;
      sysRstReq  <= 1'b0;
      cpuHaltReq <= 1'b0;
    end else begin
      pwrOffReq  <= stb.aux2Wr && wrData[AUX2_OFF_BIT];
      sysRstReq  <= stb.sysWr && wrData[SYS_GO_BIT];
      cpuHaltReq <= stb.haltWr;
    end
  end

  always_comb begin
    aux2View = '0;
    aux2View[AUX2_OFF_BIT] = auxOffQ;
    aux2View[AUX2_PF_BIT]  = auxPfQ;
  end

  always_comb begin
    case (stb.rdSel)
      SEL_CFG:  rdMux = {{(DATA_W-BYTE_W){1'b0}}, cfgQ};
      SEL_AUX1: rdMux = {{(DATA_W-BYTE_W){1'b0}}, aux1Q};
      SEL_AUX2: rdMux = {{(DATA_W-BYTE_W){1'b0}}, aux2View};
      SEL_DIAG: rdMux = {{(DATA_W-BYTE_W){1'b0}}, diagQ};
      SEL_MDM:  rdMux = {{(DATA_W-BYTE_W){1'b0}}, mdmQ};
      SEL_LED:  rdMux = {{(DATA_W-LED_W){1'b0}}, ledQ};
      SEL_SYS:  rdMux = sysQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdMux;
  end

  assign irq = auxPfQ & cfgQ[CFG_PFEN_BIT];

  // R4: the clear bit drops the power-fail flag when no input change competes
  a_r4_clear_flag: assert property (@(posedge clk) disable iff (!rstN)
    (stb.aux2Wr && wrData[AUX2_CLR_BIT] && !pfEdge) |=> !auxPfQ);

  // R3: the flag can only rise on a change of the synchronized input
  a_r3_rise_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(auxPfQ) |-> $past(pfEdge) && $past(pfSync));

  // R5: power-off pulse follows the write and lasts one cycle
  a_r5_off_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (stb.aux2Wr && wrData[AUX2_OFF_BIT]) |=> pwrOffReq);
  a_r5_off_once: assert property (@(posedge clk) disable iff (!rstN)
    (pwrOffReq && !(stb.aux2Wr && wrData[AUX2_OFF_BIT])) |=> !pwrOffReq);

  // R6: reset request loads the status word and pulses
  a_r6_sys_go: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sysWr && wrData[SYS_GO_BIT]) |=> (sysRstReq && sysQ == SYS_STATUS_VAL));
  a_r6_sys_noop: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sysWr && !wrData[SYS_GO_BIT]) |=> ($stable(sysQ) && !sysRstReq));

  // R8: halt pulse follows any write to the halt location
  a_r8_halt_pulse: assert property (@(posedge clk) disable iff (!rstN)
    stb.haltWr |=> cpuHaltReq);

  // R2: interrupt never stands without its enable
  a_r2_irq_enable: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> cfgQ[CFG_PFEN_BIT]);
endmodule

// File: rtl/sysctl_misc_regs.sv
module sysctl_misc_regs
  import sysctl_misc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              pwrFailIn,
  output logic              irq,
  output logic              pwrOffReq,
  output logic              sysRstReq,
  output logic              cpuHaltReq
);
  busStrobe_t stb;

  sysctl_misc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  sysctl_misc_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .pwrFailIn(pwrFailIn),
    .rdData(rdData), .irq(irq), .pwrOffReq(pwrOffReq),
    .sysRstReq(sysRstReq), .cpuHaltReq(cpuHaltReq)
  );
endmodule

// File: tb/tb_sysctl_misc_regs.sv
`timescale 1ns/1ps
module tb_sysctl_misc_regs;
  localparam logic [31:0] A_LED  = 32'h0160_0000;
  localparam logic [31:0] A_CFG  = 32'h0180_0000;
  localparam logic [31:0] A_AUX1 = 32'h0190_0000;
  localparam logic [31:0] A_AUX2 = 32'h0191_0000;
  localparam logic [31:0] A_HALT = 32'h0192_0000;
  localparam logic [31:0] A_DIAG = 32'h01A0_0000;
  localparam logic [31:0] A_MDM  = 32'h01B0_0000;
  localparam logic [31:0] A_SYS  = 32'h01F0_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic pwrFailIn = 1'b0;
  logic irq, pwrOffReq, sysRstReq, cpuHaltReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  bit pending = 1'b0;

  always #4 clk = ~clk;

  sysctl_misc_regs dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .pwrFailIn(pwrFailIn), .irq(irq),
    .pwrOffReq(pwrOffReq), .sysRstReq(sysRstReq), .cpuHaltReq(cpuHaltReq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares registered read data one cycle after each read strobe
  always @(negedge clk) begin
    if (pending) begin
      item_t it;
      it = sbq.pop_front();
      chk(rdData === it.exp, it.tag, rdData, it.exp);
    end
    pending = rdEn;
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic doWrite(input logic [31:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    step(1);
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic doRead(input logic [31:0] a, input logic [31:0] exp,
                        input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    addr = a; rdEn = 1'b1;
    step(1);
    rdEn = 1'b0; addr = '0;
  endtask

  task automatic pulseCheck(input logic p, input logic e, input string tag);
    chk(p === e, tag, {31'b0, p}, {31'b0, e});
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    // R7 reset state
    pulseCheck(irq, 1'b0, "R7 irq after reset");
    pulseCheck(pwrOffReq | sysRstReq | cpuHaltReq, 1'b0, "R7 no pulses after reset");
    doRead(A_CFG,  32'h0, "R7 cfg reset");
    doRead(A_AUX1, 32'h0, "R7 aux1 reset");
    doRead(A_AUX2, 32'h0, "R7 aux2 reset");
    doRead(A_MDM,  32'h0, "R7 mdm reset");

    // R11 byte registers, R10 widths
    doWrite(A_CFG,  32'hFFFF_FF52);
    doWrite(A_AUX1, 32'h0000_00C3);
    doWrite(A_DIAG, 32'h1234_5696);
    doWrite(A_MDM,  32'h0000_003C);
    doWrite(A_LED,  32'h1234_ABCD);
    doRead(A_CFG,  32'h52,   "R11 cfg readback");
    doRead(A_AUX1, 32'hC3,   "R11 aux1 readback");
    doRead(A_DIAG, 32'h96,   "R11 diag readback");
    doRead(A_MDM,  32'h3C,   "R11 mdm readback");
    doRead(A_LED,  32'hABCD, "R10 led 16-bit zero-extended");
    pulseCheck(irq, 1'b0, "R2 irq low with flag clear");

    // R1 upper address bits ignored
    doRead(32'hF180_0000, 32'h52, "R1 alias via bits 31:28");

    // R3 / R2 power fail with enable
    doWrite(A_CFG, 32'h08);
    pwrFailIn = 1'b1;
    step(2);
    pulseCheck(irq, 1'b0, "R3 irq not before synchronizer");
    step(3);
    pulseCheck(irq, 1'b1, "R2 irq raised");
    doRead(A_AUX2, 32'h20, "R3 flag set");

    // R4 write-one clear, input still high
    doWrite(A_AUX2, 32'h02);
    pulseCheck(irq, 1'b0, "R4 irq dropped by clear");
    pulseCheck(pwrOffReq, 1'b0, "R5 no power-off for clear only");
    doRead(A_AUX2, 32'h00, "R4 clear reads zero");

    // R3 enable off: no flag
    pwrFailIn = 1'b0; step(5);
    doWrite(A_CFG, 32'h00);
    pwrFailIn = 1'b1; step(5);
    doRead(A_AUX2, 32'h00, "R3 no flag without enable");
    doWrite(A_CFG, 32'h08);
    pulseCheck(irq, 1'b0, "R2 enable alone does not raise irq");
    pwrFailIn = 1'b0; step(5);
    pwrFailIn = 1'b1; step(5);
    doRead(A_AUX2, 32'h20, "R3 flag on new edge");
    doWrite(A_CFG, 32'h00);
    pulseCheck(irq, 1'b0, "R2 irq follows enable off");
    doRead(A_AUX2, 32'h20, "R2 flag kept when enable cleared");
    doWrite(A_CFG, 32'h08);
    pulseCheck(irq, 1'b1, "R2 irq follows enable on");

    // R5 power-off and R4 field behaviour
    doWrite(A_AUX2, 32'h01);
    pulseCheck(pwrOffReq, 1'b1, "R5 power-off pulse");
    step(1);
    pulseCheck(pwrOffReq, 1'b0, "R5 power-off single cycle");
    doRead(A_AUX2, 32'h21, "R4 bit0 stored, flag kept");
    doWrite(A_AUX2, 32'h03);
    pulseCheck(pwrOffReq, 1'b1, "R5 power-off with clear");
    doRead(A_AUX2, 32'h01, "R4 only bit0 survives");
    pwrFailIn = 1'b0; step(5);
    doWrite(A_AUX2, 32'hFC);
    pulseCheck(pwrOffReq, 1'b0, "R5 no pulse without bit0");
    doRead(A_AUX2, 32'h00, "R4 upper bits not writable");

    // R6 system control
    doWrite(A_SYS, 32'h1);
    pulseCheck(sysRstReq, 1'b1, "R6 reset pulse");
    step(1);
    pulseCheck(sysRstReq, 1'b0, "R6 reset pulse single cycle");
    doRead(A_SYS, 32'h2, "R6 status value");
    doWrite(A_SYS, 32'hFFFF_FFFE);
    pulseCheck(sysRstReq, 1'b0, "R6 no pulse bit0 clear");
    doRead(A_SYS, 32'h2, "R6 bit0 clear no effect");

    // R8 halt
    doWrite(A_HALT, 32'h0);
    pulseCheck(cpuHaltReq, 1'b1, "R8 halt pulse");
    step(1);
    pulseCheck(cpuHaltReq, 1'b0, "R8 halt single cycle");
    doRead(A_HALT, 32'h0, "R8 halt reads zero");

    // R9 undecoded
    doWrite(A_SYS + 32'h4, 32'h1);
    pulseCheck(sysRstReq, 1'b0, "R9 no pulse at undecoded offset");
    doWrite(A_CFG + 32'h1, 32'hFF);
    doWrite(A_HALT + 32'h2, 32'h0);
    pulseCheck(cpuHaltReq, 1'b0, "R9 no halt at undecoded offset");
    doWrite(32'h0170_0000, 32'hFF);
    doRead(A_CFG, 32'h08, "R9 cfg untouched by undecoded write");
    doRead(32'h0170_0000, 32'h0, "R9 undecoded read zero");
    doRead(A_LED + 32'h2, 32'h0, "R9 led odd offset reads zero");

    // R7 reset retention
    doWrite(A_AUX2, 32'h01);
    doReset();
    doRead(A_CFG,  32'h0,    "R7 cfg cleared");
    doRead(A_AUX1, 32'h0,    "R7 aux1 cleared");
    doRead(A_AUX2, 32'h0,    "R7 aux2 cleared");
    doRead(A_MDM,  32'h0,    "R7 mdm cleared");
    doRead(A_DIAG, 32'h96,   "R7 diag kept");
    doRead(A_LED,  32'hABCD, "R7 led kept");
    doRead(A_SYS,  32'h2,    "R7 sys status kept");
    step(3);
    chk(sbq.size() == 0, "R10 scoreboard drained", sbq.size(), 0);
    finishRun();
  end
endmodule